// File: doc/BRIEF.md
# Microcoded Memory Cycle Sequencer

This block drives the control lines of an external memory from waveforms held in a small loadable pattern store, not from a fixed state machine. Six request sources can start a pattern:

- the four bus access kinds (single read, burst read, single write, burst write);
- an internal periodic refresh timer;
- an abort condition raised by a bus error or a bus-monitor timeout.

Each source has its own fixed entry point in the store. Once a pattern starts, an index advances one word per clock. Each word sets the sixteen control lines and the transfer-acknowledge output.

A word can carry two flags. A word flagged "end" finishes the pattern. A word flagged "repeat" sends the index back to a programmable section start, a programmable number of times. A host write port loads the pattern words, the refresh period, the repeat section start, the repeat count and the idle level of the control lines. When no pattern is running, the lines sit at that idle level.

An abort takes over at once, so that a cleanup pattern can return the lines to idle. A pending refresh waits for the running pattern to finish, and then takes precedence over bus requests. A pattern that runs for the whole depth of the store without an end flag is cut off, and a sticky error flag is raised.

Top module: `memseq_top`

## Requirements
- R1: A bus request (`req_valid` high, `req_kind` 0=single read, 1=burst read, 2=single write, 3=burst write) is granted at a clock edge when the sequencer is idle and no refresh is pending. The pattern then begins at word 0x00, 0x08, 0x18 or 0x20 respectively, and `busy` is high from the following cycle.
- R2: While busy, one pattern word is executed per clock. `ctrl_out` shows word bits [15:0] and `ack_out` shows word bit 16. A word with bit 17 (end) set is the last one executed, and the sequencer is idle on the next cycle.
- R3: A word with bit 18 (repeat) set sends the index back to the section start register while the repeat count is not zero, and each such jump decrements the count. When the count is zero, the index moves to the next word. The count is reloaded from its register each time a pattern starts.
- R4: While idle, `ctrl_out` equals the idle-level register, and `ack_out` and `busy` are low.
- R5: With a non-zero period P, the refresh pattern at word 0x30 starts every P cycles. A period of 0 stops the timer. Writing the period restarts the count.
- R6: A refresh that becomes pending while a pattern runs waits until that pattern has ended. It then starts before a bus request that is also waiting.
- R7: `bus_err` or `mon_timeout` high at an edge while busy aborts the running pattern, even on its end word. The exception pattern at word 0x3C executes from the next cycle. Both inputs are ignored while idle.
- R8: A pattern that executes 64 words without an end word returns to idle after the 64th word and sets `runaway_err`. The flag stays set until reset.
- R9: Host writes (`host_we`) with `host_addr` 0x00..0x3F load pattern words. Address 0x40 loads the refresh period, 0x41 the repeat section start, 0x42 the repeat count, and 0x43 the idle level. All of these take effect from the next cycle.
- R10: After reset the sequencer is idle, the idle level, period, section start and count are 0, and `runaway_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Bus access request |
| req_kind | input | 2 | Bus access kind |
| req_grant | output | 1 | Request accepted at this edge |
| bus_err | input | 1 | Bus error abort |
| mon_timeout | input | 1 | Bus monitor timeout abort |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 7 | Host write address |
| host_wdata | input | 24 | Host write data |
| ctrl_out | output | 16 | Memory control lines |
| ack_out | output | 1 | Transfer acknowledge |
| busy | output | 1 | A pattern is running |
| runaway_err | output | 1 | Sticky missing-end error |

## Verification
A wrong index or wrong repeat count inside the sequencer shows up at the ports within a cycle. `ctrl_out` shows a different word, or `busy` lasts a different number of cycles, so every pattern run is checked for its first word, its length and the step at which acknowledge appears. A lost or stale refresh-pending bit shows up only when the next refresh or bus pattern should start, so the bench measures refresh spacing and the order of starts after a long pattern. A stuck abort path leaves an aborted pattern running, which is visible on the cycle right after the abort edge.

// File: rtl/memseq_pkg.sv
package memseq_pkg;
    // Pattern word layout shared by the store, the core and the host.
    localparam int CTRL_W = 16;
    localparam int WORD_W = 24;
    localparam int AW     = 6;

    typedef struct packed {
        logic [WORD_W-CTRL_W-4:0] spare;
        logic                     rep;
        logic                     fin;
        logic                     ack;
        logic [CTRL_W-1:0]        ctrl;
    } pword_t;

    localparam logic [AW-1:0] REFR_ENTRY = 6'h30;
    localparam logic [AW-1:0] EXC_ENTRY  = 6'h3C;

    // Entry point for each bus access kind.
    function automatic logic [AW-1:0] bus_entry(input logic [1:0] kind);
        case (kind)
            2'd0:    return 6'h00;
            2'd1:    return 6'h08;
            2'd2:    return 6'h18;
            default: return 6'h20;
        endcase
    endfunction
endpackage

// File: rtl/memseq_ram.sv
// Pattern store: single write port from the host, asynchronous read by the
// sequencer index. Assumes the host does not rewrite a word in the same
// cycle the core relies on it (the new value is seen from the next cycle).
module memseq_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Host write of one pattern word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/memseq_timer.sv
// Refresh interval timer: pulses tick once every `period` cycles.
// A period of zero holds the timer stopped; restart clears the count.
module memseq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] period,
    input  logic          restart,
    output logic          tick
);
    logic [TW-1:0] cnt;

    assign tick = (period != '0) && (cnt == period - 1'b1);

    // Count cycles since the last tick or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt <= '0;
        else if (restart || tick || period == '0)   cnt <= '0;
        else                                        cnt <= cnt + 1'b1;
    end

    // R5
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
endmodule

// File: rtl/memseq_core.sv
// Sequencer core: arbitrates between abort, refresh and bus requests,
// steps the pattern index one word per clock, handles repeat and end
// flags, and cuts off patterns that never reach an end word.
// Assumes an asynchronous-read pattern store addressed by idx.
module memseq_core
    import memseq_pkg::*;
#(
    parameter int STEP_LIMIT = 64,
    parameter int CW         = 8,
    localparam int SW        = $clog2(STEP_LIMIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pword_t            word,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              abort_in,
    input  logic              refr_tick,
    input  logic [AW-1:0]     sect_start,
    input  logic [CW-1:0]     rep_count,
    input  logic [CTRL_W-1:0] idle_ctrl,
    output logic [AW-1:0]     idx,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              ack_out,
    output logic              busy,
    output logic              req_grant,
    output logic              runaway_err
);
    logic          running;
    logic          refr_pend;
    logic [CW-1:0] rep_left;
    logic [SW-1:0] step_cnt;
    logic          abort, start_refr, runaway;

    // Priority: abort, then pending refresh, then bus request.
    always_comb begin
        abort      = running && abort_in;
        start_refr = !running && refr_pend;
        req_grant  = !running && !refr_pend && req_valid;
        runaway    = running && !abort && !word.fin
                     && (step_cnt == SW'(STEP_LIMIT - 1));
    end

    // Remember a refresh tick until its pattern starts.
    always_ff @(posedge clk) begin
        if (!rst_n) refr_pend <= 1'b0;
        else        refr_pend <= refr_tick | (refr_pend & !start_refr);
    end

    // Pattern start, stepping, repeat and termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running     <= 1'b0;
            idx         <= '0;
            rep_left    <= '0;
            step_cnt    <= '0;
            runaway_err <= 1'b0;
        end else if (abort) begin
            running  <= 1'b1;
            idx      <= EXC_ENTRY;
            rep_left <= rep_count;
            step_cnt <= '0;
        end else if (start_refr || req_grant) begin
            running  <= 1'b1;
            idx      <= start_refr ? REFR_ENTRY : bus_entry(req_kind);
            rep_left <= rep_count;
            step_cnt <= '0;
        end else if (running) begin
            if (word.fin || runaway) begin
                running <= 1'b0;
                if (runaway) runaway_err <= 1'b1;
            end else begin
                step_cnt <= step_cnt + 1'b1;
                if (word.rep && rep_left != '0) begin
                    idx      <= sect_start;
                    rep_left <= rep_left - 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // Drive lines from the current word, or the idle level.
    always_comb begin
        busy     = running;
        ctrl_out = running ? word.ctrl : idle_ctrl;
        ack_out  = running && word.ack;
    end

    // R1
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |=> running);
    // R2
    end_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && word.fin && !abort_in) |=> !running);
    // R6
    refr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refr_pend && !running) |=> (running && idx == REFR_ENTRY));
    // R7
    abort_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (running && idx == EXC_ENTRY));
    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        runaway_err |=> runaway_err);
    // R8
    runaway_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(runaway_err) |-> !running);
endmodule

// File: rtl/memseq_top.sv
// Memory cycle sequencer top: host register decode, pattern store,
// refresh timer and sequencer core. Assumes host writes and requests
// are synchronous to clk.
module memseq_top
    import memseq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int TW    = 16,
    parameter int CW    = 8,
    parameter int HAW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    output logic              req_grant,
    input  logic              bus_err,
    input  logic              mon_timeout,
    input  logic              host_we,
    input  logic [HAW-1:0]    host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              ack_out,
    output logic              busy,
    output logic              runaway_err
);
    localparam logic [HAW-1:0] A_PERIOD = HAW'(DEPTH);
    localparam logic [HAW-1:0] A_SECT   = HAW'(DEPTH + 1);
    localparam logic [HAW-1:0] A_COUNT  = HAW'(DEPTH + 2);
    localparam logic [HAW-1:0] A_IDLE   = HAW'(DEPTH + 3);

    logic [TW-1:0]     period_q;
    logic [AW-1:0]     sect_q;
    logic [CW-1:0]     count_q;
    logic [CTRL_W-1:0] idle_q;
    logic [AW-1:0]     idx;
    logic [WORD_W-1:0] rdata;
    logic              tick, ram_we;

    assign ram_we = host_we && (host_addr < HAW'(DEPTH));

    // Host-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            sect_q   <= '0;
            count_q  <= '0;
            idle_q   <= '0;
        end else if (host_we) begin
            if (host_addr == A_PERIOD) period_q <= host_wdata[TW-1:0];
            if (host_addr == A_SECT)   sect_q   <= host_wdata[AW-1:0];
            if (host_addr == A_COUNT)  count_q  <= host_wdata[CW-1:0];
            if (host_addr == A_IDLE)   idle_q   <= host_wdata[CTRL_W-1:0];
        end
    end

    memseq_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (host_addr[AW-1:0]),
        .wdata (host_wdata),
        .raddr (idx),
        .rdata (rdata)
    );

    memseq_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .period  (period_q),
        .restart (host_we && host_addr == A_PERIOD),
        .tick    (tick)
    );

    memseq_core #(.STEP_LIMIT(DEPTH), .CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .word        (pword_t'(rdata)),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .abort_in    (bus_err || mon_timeout),
        .refr_tick   (tick),
        .sect_start  (sect_q),
        .rep_count   (count_q),
        .idle_ctrl   (idle_q),
        .idx         (idx),
        .ctrl_out    (ctrl_out),
        .ack_out     (ack_out),
        .busy        (busy),
        .req_grant   (req_grant),
        .runaway_err (runaway_err)
    );

    // R4
    idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ack_out && ctrl_out == idle_q));
endmodule

// File: tb/test_memseq_top.sv
module test_memseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_grant;
    logic        bus_err = 1'b0;
    logic        mon_timeout = 1'b0;
    logic        host_we = 1'b0;
    logic [6:0]  host_addr = '0;
    logic [23:0] host_wdata = '0;
    logic [15:0] ctrl_out;
    logic        ack_out, busy, runaway_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    memseq_top i_memseq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_grant(req_grant), .bus_err(bus_err), .mon_timeout(mon_timeout),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .ctrl_out(ctrl_out), .ack_out(ack_out), .busy(busy),
        .runaway_err(runaway_err)
    );

    // Vector: {kind, length, first ctrl word, ack step}
    localparam logic [33:0] VEC [5] = '{
        {2'd0, 8'd3, 16'h1001, 8'd2},
        {2'd1, 8'd5, 16'h2001, 8'd4},
        {2'd2, 8'd1, 16'h3001, 8'd0},
        {2'd3, 8'd4, 16'h4001, 8'd2},
        {2'd1, 8'd5, 16'h2001, 8'd4}
    };

    function automatic logic [23:0] pw(input logic [15:0] c, input bit a,
                                       input bit f, input bit r);
        return {5'b0, r, f, a, c};
    endfunction

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [6:0] a, input logic [23:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run_req(input logic [1:0] k, output int len,
                           output logic [15:0] first, output int ack_at);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
        len = 0; ack_at = -1; first = ctrl_out;
        while (busy && len < 200) begin
            if (ack_out && ack_at < 0) ack_at = len;
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int len, ack_at, t1, t2, cyc;
        logic [15:0] first;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 ctrl", ctrl_out, 16'h0000);
        chk("R10 err", runaway_err, 0);

        for (int i = 0; i < 64; i++) host_write(7'(i), 24'h0);
        host_write(7'h00, pw(16'h1001, 0, 0, 0));
        host_write(7'h01, pw(16'h1002, 0, 0, 0));
        host_write(7'h02, pw(16'h1003, 1, 1, 0));
        host_write(7'h08, pw(16'h2001, 0, 0, 0));
        host_write(7'h09, pw(16'h2002, 0, 0, 1));
        host_write(7'h0A, pw(16'h2003, 1, 1, 0));
        host_write(7'h18, pw(16'h3001, 1, 1, 0));
        host_write(7'h20, pw(16'h4001, 0, 0, 0));
        host_write(7'h21, pw(16'h4002, 0, 0, 0));
        host_write(7'h22, pw(16'h4003, 1, 0, 0));
        host_write(7'h23, pw(16'h4004, 0, 1, 0));
        host_write(7'h30, pw(16'h5001, 0, 0, 0));
        host_write(7'h31, pw(16'h5002, 0, 1, 0));
        host_write(7'h3C, pw(16'hA5A5, 0, 1, 0));
        host_write(7'h41, 24'd9);
        host_write(7'h42, 24'd2);
        host_write(7'h43, 24'h00A5A5);
        @(negedge clk);
        // R4 / R9 idle level
        chk("R4 idle ctrl", ctrl_out, 16'hA5A5);
        chk("R4 idle ack", ack_out, 0);

        // R1 R2 R3 table walk
        foreach (VEC[i]) begin
            run_req(VEC[i][33:32], len, first, ack_at);
            chk("R1 first word", first, VEC[i][23:8]);
            chk("R2 length", len, VEC[i][31:24]);
            chk("R2 ack step", ack_at, VEC[i][7:0]);
            chk("R3 idle after", ctrl_out, 16'hA5A5);
        end

        // R7 abort by bus_err in mid pattern
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd1;
        @(negedge clk); req_valid = 1'b0;
        chk("R7 pre abort", ctrl_out, 16'h2001);
        bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        chk("R7 exc busy", busy, 1);
        chk("R7 exc word", ctrl_out, 16'hA5A5);
        @(negedge clk);
        chk("R7 exc done", busy, 0);
        // R7 abort wins over end word
        @(negedge clk); req_valid = 1'b1; req_kind = 2'd2;
        @(negedge clk); req_valid = 1'b0; mon_timeout = 1'b1;
        @(negedge clk); mon_timeout = 1'b0;
        chk("R7 timeout exc", {busy, ctrl_out}, {1'b1, 16'hA5A5});
        @(negedge clk);
        // R7 ignored while idle
        bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        chk("R7 idle ignore", busy, 0);

        // R5 refresh spacing
        host_write(7'h40, 24'd40);
        t1 = -1; t2 = -1; prev = 0;
        for (int c = 0; c < 200 && t2 < 0; c++) begin
            @(negedge clk);
            if (busy && ctrl_out == 16'h5001 && !prev) begin
                if (t1 < 0) t1 = c; else t2 = c;
            end
            prev = busy && ctrl_out == 16'h5001;
        end
        chk("R5 interval", t2 - t1, 40);
        host_write(7'h40, 24'd0);
        repeat (5) @(negedge clk);
        cyc = 0;
        for (int c = 0; c < 100; c++) begin
            @(negedge clk);
            if (busy) cyc++;
        end
        chk("R5 stopped", cyc, 0);

        // R6 refresh waits for end, then beats a waiting bus request
        host_write(7'h40, 24'd3);
        req_valid = 1'b1; req_kind = 2'd1;
        @(negedge clk);
        chk("R6 bus first", ctrl_out, 16'h2001);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R6 refresh next", {busy, ctrl_out}, {1'b1, 16'h5001});
        req_valid = 1'b0;
        host_write(7'h40, 24'd0);
        repeat (20) @(negedge clk);
        chk("R6 drained", busy, 0);

        // R8 runaway
        chk("R8 err before", runaway_err, 0);
        host_write(7'h18, pw(16'h7777, 0, 0, 1));
        host_write(7'h41, 24'h18);
        host_write(7'h42, 24'd255);
        run_req(2'd2, len, first, ack_at);
        chk("R8 length", len, 64);
        chk("R8 err set", runaway_err, 1);
        chk("R8 idle", ctrl_out, 16'hA5A5);
        run_req(2'd0, len, first, ack_at);
        chk("R8 sticky", runaway_err, 1);

        // R10 reset clears
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 err clear", runaway_err, 0);
        chk("R10 idle clear", ctrl_out, 16'h0000);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule